// File: doc/BRIEF.md
# PWM Channel Group with Buffered Waveform Updates

The block drives a group of pulse-width-modulated channels. Each channel owns a period counter, a duty comparator and a complementary high-side/low-side output pair, with a separate dead-time delay on the rising edge of each side. Software changes period, duty and dead time while a channel runs. It writes them into shadow registers, and the block copies the shadow registers into the active registers only at safe instants, so no period is ever built from a mix of old and new settings.

Each channel is either free-running (asynchronous) or part of the synchronous set. A free-running channel applies new settings at the end of its own period. Synchronous channels count on channel 0's counter and share one update policy. Period and dead time always wait for a software unlock, and duty either waits for the same unlock or is released on a slow cadence set by a shared update-period counter. A disabled channel takes register writes straight into its active settings.

Top module: `pwmgrp_top`

## Requirements
- R1: An asynchronous enabled channel with period P counts 0 to P-1 and wraps, so its high-side output rises exactly once every P cycles.
- R2: With duty D (1 to P-1), high-side dead time Th and low-side dead time Tl, the high-side output is high for D-Th consecutive cycles per period and the low-side output for P-D-Tl cycles, and the two are never high in the same cycle.
- R3: When a dead time is equal to or longer than the interval it delays (Th >= D, or Tl >= P-D), that output stays low for the whole period.
- R4: After reset and while a channel is disabled, both of its outputs are low. Period, duty and dead-time writes to a disabled channel take effect at once, so the first period after enabling already uses them.
- R5: For an asynchronous channel, values written during a period leave that period unchanged and apply from the next period.
- R6: When a shadow register is written more than once before an update instant, only the last value is applied.
- R7: For a synchronous channel in update mode 0 or 3, new period, duty and dead time are held until 1 is written to the unlock bit. They are then applied from the period after the next channel-0 end of period.
- R8: The unlock bit clears itself at the end of period where it causes a transfer. Later shadow writes then wait for a new unlock.
- R9: In update mode 1 or 2, a synchronous channel's duty is transferred without unlock at a channel-0 end of period where the update-period counter equals the programmed value U, which happens once every U+1 periods. Period and dead time still need the unlock.
- R10: Synchronous channels run on channel 0's counter. They have channel 0's period, and their high-side rising edges coincide with channel 0's when their high-side dead times match.
- R11: Register map (data bit 0 is the LSB). Address 4c+0 is the period of channel c, 4c+1 its duty, 4c+2 its dead times (high side in bits [DTW-1:0], low side in bits [2DTW-1:DTW]), and 4c+3 its control (bit 0 enable, bit 1 synchronous). Address 4·NCH+0 is the update mode in bits [1:0], 4·NCH+1 the update period U, and 4·NCH+2 the unlock (writing 1 to bit 0 sets it).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register address (see R11) |
| wr_data | input | CW | Register write data |
| pwm_hi | output | NCH | High-side outputs, one per channel |
| pwm_lo | output | NCH | Low-side outputs, one per channel |

## Verification
Two functions can fall on the same channel-0 end of period. The unlocked period transfer and the paced duty transfer can both happen there, and a software unlock or shadow write can also land in the cycle of a transfer. The bench provokes this by running the synchronous pair in the paced mode with pending duty and period writes, unlocking at arbitrary points in the period. It judges each outcome only from measured pulse widths and rise-to-rise intervals, which must show the old settings before the allowed instant and the new ones after it. Random free-running configurations add unaligned write timing against the end of period.

// File: rtl/pwmgrp_pkg.sv
package pwmgrp_pkg;
  // register slot layout per channel and global block
  localparam int unsigned SLOT     = 4;
  localparam int unsigned OFS_PRD  = 0;
  localparam int unsigned OFS_DTY  = 1;
  localparam int unsigned OFS_DT   = 2;
  localparam int unsigned OFS_CTL  = 3;
  localparam int unsigned GLB_MODE = 0;
  localparam int unsigned GLB_UPR  = 1;
  localparam int unsigned GLB_UNLK = 2;

  typedef enum logic [1:0] {
    UPD_LOCK     = 2'd0,
    UPD_PACE_A   = 2'd1,
    UPD_PACE_B   = 2'd2,
    UPD_LOCK_ALT = 2'd3
  } upd_mode_e;

  function automatic logic mode_paced(upd_mode_e m);
    return (m == UPD_PACE_A) || (m == UPD_PACE_B);
  endfunction
endpackage

// File: rtl/pwmgrp_chan.sv
module pwmgrp_chan #(
  parameter int CW   = 8,
  parameter int DTW  = 4,
  parameter bit LEAD = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  input  logic            sync_i,
  input  logic            paced_i,
  input  logic [CW-1:0]   cnt_ext_i,
  input  logic            lock_go_i,
  input  logic            pace_go_i,
  input  logic            wr_prd_i,
  input  logic            wr_dty_i,
  input  logic            wr_dt_i,
  input  logic [CW-1:0]   wdat_i,
  output logic [CW-1:0]   cnt_o,
  output logic            eop_o,
  output logic            hi_o,
  output logic            lo_o
);
  localparam int DTB = 2 * DTW;

  logic [CW-1:0]  prd_sh_q, prd_sh_n, dty_sh_q, dty_sh_n;
  logic [CW-1:0]  prd_act_q, prd_act_n, dty_act_q, dty_act_n;
  logic [DTB-1:0] dt_sh_q, dt_sh_n, dt_act_q, dt_act_n;
  logic [CW-1:0]  cnt_q, cnt_n, cnt_use;
  logic [DTW-1:0] dcnt_q, dcnt_n;
  logic           raw, raw_q;
  logic           run, eop_own, go_pd, go_dy;

  assign run     = en_i && (LEAD || !sync_i);
  assign eop_own = run && (cnt_q == prd_act_q - CW'(1));
  assign go_pd   = en_i && (sync_i ? lock_go_i : eop_own);
  assign go_dy   = en_i && (sync_i ? (paced_i ? pace_go_i : lock_go_i) : eop_own);
  assign cnt_use = (sync_i && !LEAD) ? cnt_ext_i : cnt_q;
  assign raw     = en_i && (cnt_use < dty_act_q);

  always_comb begin
    prd_sh_n  = wr_prd_i ? wdat_i : prd_sh_q;
    dty_sh_n  = wr_dty_i ? wdat_i : dty_sh_q;
    dt_sh_n   = wr_dt_i  ? wdat_i[DTB-1:0] : dt_sh_q;
    prd_act_n = prd_act_q;
    dty_act_n = dty_act_q;
    dt_act_n  = dt_act_q;
    if (!en_i && wr_prd_i)   prd_act_n = wdat_i;
    else if (go_pd)          prd_act_n = prd_sh_q;
    if (!en_i && wr_dt_i)    dt_act_n  = wdat_i[DTB-1:0];
    else if (go_pd)          dt_act_n  = dt_sh_q;
    if (!en_i && wr_dty_i)   dty_act_n = wdat_i;
    else if (go_dy)          dty_act_n = dty_sh_q;
    if (!run)                cnt_n = '0;
    else if (eop_own)        cnt_n = '0;
    else                     cnt_n = cnt_q + CW'(1);
    if (raw != raw_q)        dcnt_n = raw ? dt_act_q[DTW-1:0] : dt_act_q[DTB-1:DTW];
    else if (dcnt_q != '0)   dcnt_n = dcnt_q - DTW'(1);
    else                     dcnt_n = dcnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prd_sh_q  <= '0;
      dty_sh_q  <= '0;
      dt_sh_q   <= '0;
      prd_act_q <= '0;
      dty_act_q <= '0;
      dt_act_q  <= '0;
      cnt_q     <= '0;
      dcnt_q    <= '0;
      raw_q     <= 1'b0;
    end else begin
      prd_sh_q  <= prd_sh_n;
      dty_sh_q  <= dty_sh_n;
      dt_sh_q   <= dt_sh_n;
      prd_act_q <= prd_act_n;
      dty_act_q <= dty_act_n;
      dt_act_q  <= dt_act_n;
      cnt_q     <= cnt_n;
      dcnt_q    <= dcnt_n;
      raw_q     <= raw;
    end
  end

  assign cnt_o = cnt_q;
  assign eop_o = eop_own;
  assign hi_o  = en_i && raw_q  && (dcnt_q == '0);
  assign lo_o  = en_i && !raw_q && (dcnt_q == '0);

  // R1: a running counter never reaches its active period
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && prd_act_q != '0) |-> (cnt_q < prd_act_q));
  // R5: free-running channel holds active settings between its ends of period
  p_async_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !sync_i && !eop_own) |=>
      ($stable(prd_act_q) && $stable(dty_act_q) && $stable(dt_act_q)));
  // R7: synchronous period and dead time move only on an unlocked transfer
  p_lock_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && sync_i && !lock_go_i) |=> ($stable(prd_act_q) && $stable(dt_act_q)));
  // R9: paced duty moves only on a pacing instant
  p_pace_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && sync_i && paced_i && !pace_go_i) |=> $stable(dty_act_q));
endmodule

// File: rtl/pwmgrp_sync_ctl.sv
module pwmgrp_sync_ctl #(
  parameter int UPW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           eop0_i,
  input  logic           unlk_wr_i,
  input  logic           upr_wr_i,
  input  logic [UPW-1:0] upr_dat_i,
  output logic           lock_go_o,
  output logic           pace_go_o
);
  logic           unlk_q, unlk_n;
  logic [UPW-1:0] upr_q, upr_n, upc_q, upc_n;

  assign lock_go_o = eop0_i && unlk_q;
  assign pace_go_o = eop0_i && (upc_q == upr_q);

  always_comb begin
    upr_n = upr_wr_i ? upr_dat_i : upr_q;
    if (unlk_wr_i)      unlk_n = 1'b1;
    else if (lock_go_o) unlk_n = 1'b0;
    else                unlk_n = unlk_q;
    if (!eop0_i)        upc_n = upc_q;
    else if (pace_go_o) upc_n = '0;
    else                upc_n = upc_q + UPW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlk_q <= 1'b0;
      upr_q  <= '0;
      upc_q  <= '0;
    end else begin
      unlk_q <= unlk_n;
      upr_q  <= upr_n;
      upc_q  <= upc_n;
    end
  end

  // R8: unlock drops after the transfer it triggered
  p_unlock_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_go_o && !unlk_wr_i) |=> !unlk_q);
  // R9: pacing counter restarts after a pacing instant
  p_pace_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pace_go_o |=> (upc_q == '0));
  // R9: pacing counter steps once per channel-0 end of period
  p_pace_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (eop0_i && !pace_go_o) |=> (upc_q == $past(upc_q) + UPW'(1)));
endmodule

// File: rtl/pwmgrp_top.sv
module pwmgrp_top
  import pwmgrp_pkg::*;
#(
  parameter  int NCH   = 4,
  parameter  int CW    = 8,
  parameter  int DTW   = 4,
  parameter  int UPW   = 4,
  localparam int GBASE = NCH * SLOT,
  localparam int AW    = $clog2(GBASE + 3)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [CW-1:0]  wr_data,
  output logic [NCH-1:0] pwm_hi,
  output logic [NCH-1:0] pwm_lo
);
  logic [NCH-1:0] en_q, en_n, sync_q, sync_n;
  upd_mode_e      mode_q, mode_n;
  logic [CW-1:0]  cnt0;
  logic           eop0, lock_go, pace_go, paced;

  assign paced = mode_paced(mode_q);

  always_comb begin
    en_n   = en_q;
    sync_n = sync_q;
    mode_n = mode_q;
    for (int i = 0; i < NCH; i++) begin
      if (wr_en && wr_addr == AW'(i * SLOT + OFS_CTL)) begin
        en_n[i]   = wr_data[0];
        sync_n[i] = wr_data[1];
      end
    end
    if (wr_en && wr_addr == AW'(GBASE + GLB_MODE)) mode_n = upd_mode_e'(wr_data[1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      sync_q <= '0;
      mode_q <= UPD_LOCK;
    end else begin
      en_q   <= en_n;
      sync_q <= sync_n;
      mode_q <= mode_n;
    end
  end

  pwmgrp_sync_ctl #(.UPW(UPW)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .eop0_i    (eop0),
    .unlk_wr_i (wr_en && wr_addr == AW'(GBASE + GLB_UNLK) && wr_data[0]),
    .upr_wr_i  (wr_en && wr_addr == AW'(GBASE + GLB_UPR)),
    .upr_dat_i (wr_data[UPW-1:0]),
    .lock_go_o (lock_go),
    .pace_go_o (pace_go)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic wp, wd, wt;
    assign wp = wr_en && wr_addr == AW'(i * SLOT + OFS_PRD);
    assign wd = wr_en && wr_addr == AW'(i * SLOT + OFS_DTY);
    assign wt = wr_en && wr_addr == AW'(i * SLOT + OFS_DT);
    if (i == 0) begin : g_lead
      pwmgrp_chan #(.CW(CW), .DTW(DTW), .LEAD(1'b1)) u_ch (
        .clk(clk), .rst_n(rst_n), .en_i(en_q[i]), .sync_i(sync_q[i]), .paced_i(paced),
        .cnt_ext_i(cnt0), .lock_go_i(lock_go), .pace_go_i(pace_go),
        .wr_prd_i(wp), .wr_dty_i(wd), .wr_dt_i(wt), .wdat_i(wr_data),
        .cnt_o(cnt0), .eop_o(eop0), .hi_o(pwm_hi[i]), .lo_o(pwm_lo[i]));
    end else begin : g_follow
      logic [CW-1:0] cnt_unused;
      logic          eop_unused;
      pwmgrp_chan #(.CW(CW), .DTW(DTW), .LEAD(1'b0)) u_ch (
        .clk(clk), .rst_n(rst_n), .en_i(en_q[i]), .sync_i(sync_q[i]), .paced_i(paced),
        .cnt_ext_i(cnt0), .lock_go_i(lock_go), .pace_go_i(pace_go),
        .wr_prd_i(wp), .wr_dty_i(wd), .wr_dt_i(wt), .wdat_i(wr_data),
        .cnt_o(cnt_unused), .eop_o(eop_unused), .hi_o(pwm_hi[i]), .lo_o(pwm_lo[i]));
    end
  end

  // R4: a disabled channel drives neither side
  p_off_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwm_hi | pwm_lo) & ~en_q) == '0);
endmodule

// File: tb/pwmgrp_top_tb_top.sv
module pwmgrp_top_tb_top;
  localparam int NCH = 4;
  localparam int CW  = 8;
  localparam int DTW = 4;
  localparam int UPW = 4;
  localparam int GB  = NCH * 4;
  localparam int AW  = $clog2(GB + 3);

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en;
  logic [AW-1:0] wr_addr;
  logic [CW-1:0] wr_data;
  logic [NCH-1:0] pwm_hi, pwm_lo;

  always #5 clk = ~clk;

  pwmgrp_top #(.NCH(NCH), .CW(CW), .DTW(DTW), .UPW(UPW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo));

  int n_chk = 0, n_fail = 0, cyc = 0, overlap = 0;
  bit done = 1'b0;
  int hrun[NCH], lrun[NCH], hw[NCH], lw[NCH], hcnt[NCH], lcnt[NCH];
  int per[NCH], rise_t[NCH];
  bit ph[NCH], pl[NCH];

  // pulse monitor, samples away from the active edge
  always @(negedge clk) begin
    cyc++;
    for (int c = 0; c < NCH; c++) begin
      if (pwm_hi[c] && pwm_lo[c]) overlap++;
      if (pwm_hi[c]) begin
        if (!ph[c]) begin per[c] = cyc - rise_t[c]; rise_t[c] = cyc; hrun[c] = 0; end
        hrun[c]++;
      end else if (ph[c]) begin hw[c] = hrun[c]; hcnt[c]++; end
      if (pwm_lo[c]) begin
        if (!pl[c]) lrun[c] = 0;
        lrun[c]++;
      end else if (pl[c]) begin lw[c] = lrun[c]; lcnt[c]++; end
      ph[c] = pwm_hi[c];
      pl[c] = pwm_lo[c];
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    if (!done && cyc > 150000) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog (R1..all): actual %0d cycles expected fewer than 150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_hi(int dty, int dth);
    return (dty > dth) ? dty - dth : 0;
  endfunction
  function automatic int exp_lo(int prd, int dty, int dtl);
    return (prd - dty > dtl) ? prd - dty - dtl : 0;
  endfunction

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = CW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // R11 map: 4c+0 period, +1 duty, +2 dead times, +3 control
  task automatic cfg(int ch, int prd, int dty, int dth, int dtl, int sync);
    wr(ch * 4 + 3, 0);
    wr(ch * 4 + 0, prd);
    wr(ch * 4 + 1, dty);
    wr(ch * 4 + 2, (dtl << DTW) | dth);
    wr(ch * 4 + 3, 1 | (sync << 1));
  endtask

  task automatic wait_hi(int c, output int w);
    int s = hcnt[c];
    int k = 0;
    while (hcnt[c] == s && k < 3000) begin @(posedge clk); k++; end
    w = (hcnt[c] == s) ? -1 : hw[c];
  endtask

  task automatic wait_lo(int c, output int w);
    int s = lcnt[c];
    int k = 0;
    while (lcnt[c] == s && k < 3000) begin @(posedge clk); k++; end
    w = (lcnt[c] == s) ? -1 : lw[c];
  endtask

  task automatic wait_rise(int c);
    int s = rise_t[c];
    int k = 0;
    while (rise_t[c] == s && k < 3000) begin @(posedge clk); k++; end
  endtask

  initial begin
    int w, s, found;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R4", "outputs after reset", int'({pwm_hi, pwm_lo}), 0);

    // R1 R2: free-running channel 0
    cfg(0, 20, 8, 2, 3, 0);
    wait_hi(0, w); wait_hi(0, w); wait_hi(0, w);
    chk("R2", "ch0 high width", w, exp_hi(8, 2));
    chk("R1", "ch0 rise interval", per[0], 20);
    wait_lo(0, w);
    chk("R2", "ch0 low width", w, exp_lo(20, 8, 3));

    // R3: clamped high side on ch2, clamped low side on ch3
    cfg(2, 16, 4, 5, 0, 0);
    cfg(3, 10, 8, 0, 4, 0);
    idle(40);
    s = hcnt[2];
    idle(64);
    chk("R3", "ch2 high pulses under clamp", hcnt[2] - s, 0);
    wait_lo(2, w);
    chk("R3", "ch2 low width", w, exp_lo(16, 4, 0));
    s = lcnt[3];
    idle(50);
    chk("R3", "ch3 low pulses under clamp", lcnt[3] - s, 0);
    wait_hi(3, w);
    chk("R3", "ch3 high width", w, 8);

    // R4: disabled channel stays quiet, direct writes used at enable
    wr(2 * 4 + 3, 0);
    idle(2);
    s = 0;
    for (int k = 0; k < 30; k++) begin @(negedge clk); if (pwm_hi[2] || pwm_lo[2]) s++; end
    chk("R4", "ch2 active cycles while disabled", s, 0);
    wr(2 * 4 + 0, 12); wr(2 * 4 + 1, 7); wr(2 * 4 + 2, (1 << DTW) | 1);
    wr(2 * 4 + 3, 1);
    wait_hi(2, w);
    chk("R4", "ch2 first pulse after enable", w, exp_hi(7, 1));

    // R5: duty written inside a running high pulse
    wait_hi(0, w);
    wait_rise(0);
    wr(0 * 4 + 1, 10);
    wait_hi(0, w);
    chk("R5", "ch0 pulse of write period", w, exp_hi(8, 2));
    wait_hi(0, w);
    chk("R5", "ch0 pulse of next period", w, exp_hi(10, 2));

    // R6: two writes between updates
    wait_hi(0, w);
    wr(0 * 4 + 1, 4);
    wr(0 * 4 + 1, 12);
    wait_hi(0, w);
    chk("R6", "ch0 first pulse after double write", w, exp_hi(12, 2));
    wait_hi(0, w);
    chk("R6", "ch0 second pulse after double write", w, exp_hi(12, 2));

    // random free-running configurations on ch1 (R1 R2)
    void'($urandom(32'd1234));
    for (int it = 0; it < 20; it++) begin
      int prd, dty, dth, dtl, m;
      prd = 6 + int'($urandom % 35);
      dty = 1 + int'($urandom % (prd - 1));
      m   = (dty < 16) ? dty : 16;
      dth = int'($urandom % m);
      m   = (prd - dty < 16) ? prd - dty : 16;
      dtl = int'($urandom % m);
      cfg(1, prd, dty, dth, dtl, 0);
      wait_hi(1, w); wait_hi(1, w); wait_hi(1, w);
      chk("R2", "ch1 random high width", w, exp_hi(dty, dth));
      chk("R1", "ch1 random rise interval", per[1], prd);
      wait_lo(1, w); wait_lo(1, w);
      chk("R2", "ch1 random low width", w, exp_lo(prd, dty, dtl));
    end

    // R7 R10: synchronous pair, locked mode
    for (int c = 0; c < NCH; c++) wr(c * 4 + 3, 0);
    wr(GB + 0, 0);
    cfg(0, 20, 5, 0, 0, 1);
    cfg(1, 20, 10, 0, 0, 1);
    wait_hi(1, w); wait_hi(1, w); wait_hi(1, w);
    chk("R10", "ch1 high width on shared counter", w, 10);
    chk("R10", "ch1 rise interval", per[1], 20);
    chk("R10", "ch0/ch1 rise alignment", rise_t[1] - rise_t[0], 0);
    wr(0 * 4 + 0, 30);
    wr(1 * 4 + 1, 14);
    for (int k = 0; k < 3; k++) begin
      wait_hi(1, w);
      chk("R7", "ch1 width before unlock", w, 10);
      chk("R7", "ch1 interval before unlock", per[1], 20);
    end
    wr(GB + 2, 1);
    wait_hi(1, w); wait_hi(1, w); wait_hi(1, w);
    chk("R7", "ch1 width after unlock", w, 14);
    chk("R7", "ch1 interval after unlock", per[1], 30);

    // R8: unlock is consumed
    wr(1 * 4 + 1, 3);
    for (int k = 0; k < 4; k++) wait_hi(1, w);
    chk("R8", "ch1 width after spent unlock", w, 14);

    // R9: paced duty, locked period
    wr(GB + 1, 2);
    wr(GB + 0, 1);
    for (int k = 0; k < 5; k++) wait_hi(1, w);
    chk("R9", "ch1 paced duty applied", w, 3);
    chk("R9", "ch1 interval unchanged in paced mode", per[1], 30);
    wr(0 * 4 + 0, 24);
    for (int k = 0; k < 4; k++) wait_hi(1, w);
    chk("R9", "ch1 interval held without unlock", per[1], 30);
    wr(1 * 4 + 1, 9);
    found = 0;
    for (int k = 1; k <= 6; k++) begin
      wait_hi(1, w);
      if (found == 0 && w == 9) found = k;
    end
    chk("R9", "paced duty reached within U+2 pulses", int'(found >= 1 && found <= 4), 1);
    wr(GB + 2, 1);
    wait_hi(1, w); wait_hi(1, w); wait_hi(1, w);
    chk("R9", "ch1 interval after unlock in paced mode", per[1], 24);
    chk("R9", "ch1 duty kept after unlock", w, 9);

    chk("R2", "cycles with both sides high", overlap, 0);

    if (!done) begin
      done = 1'b1;
      summary();
      $finish;
    end
  end
endmodule